// File: doc/BRIEF.md
# Three-Level-Select Feedback Clock Divider

This block divides a fast source clock by one of nine ratios, chosen by two select inputs. Each select carries a LOW, MID or HIGH level that has already been resolved into a two-bit code. The divided clock leaves the block as a matched pair of identical outputs that feed a phase-locked loop's feedback path. Every ratio, odd or even, gives an exact 50% duty cycle. Two companion banks, of two outputs each, carry the source clock undivided.

A ratio change never truncates the period in progress. The new ratio is loaded only when the current output period ends. A synchronous park input blanks every output. When park is held for enough source-clock rising edges, the divider is frozen in a state that depends only on the select codes, so the phase after release is known exactly. An asynchronous active-low reset clears the block; its release is synchronized to the source clock.

Top module: `fbdiv_top`

## Requirements
- R1: Select codes are 2'b00 = LOW, 2'b01 = MID and 2'b10 = HIGH. The pair (upper select, lower select) maps to these ratios: LOW/LOW 1, LOW/MID 2, LOW/HIGH 3, MID/LOW 4, MID/MID 5, MID/HIGH 6, HIGH/LOW 8, HIGH/MID 10, HIGH/HIGH 12.
- R2: On either select, code 2'b11 gives the same ratio as MID.
- R3: For ratio N, each output period of `fb_o` lasts N source-clock cycles. The output is high for exactly N half-cycles and low for exactly N half-cycles, and every period starts with a rise at a source-clock rising edge.
- R4: Both bits of `fb_o` carry identical waveforms at all times.
- R5: While running, every bit of `bank_a_o` and `bank_b_o` follows the source clock undivided, for every select setting.
- R6: A select change made during an output period leaves that period at the old ratio. The new ratio applies from the next period on.
- R7: From the first rising edge that samples `park_i` high, all outputs stay low while park remains asserted.
- R8: Park is held for at least 5 rising edges, and then a rising edge samples `park_i` low. `fb_o` rises at that edge, and its first period already has the full length of the ratio the selects give at release, independent of the phase before parking.
- R9: While `rst_ni` is low, all outputs are low and the counters are cleared. Assertion takes effect at once; release passes through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_hi_i | input | 2 | Upper ratio select level code |
| sel_lo_i | input | 2 | Lower ratio select level code |
| park_i | input | 1 | Synchronous forced park / test reset |
| fb_o | output | 2 | Matched divided feedback pair |
| bank_a_o | output | 2 | Companion bank A, undivided |
| bank_b_o | output | 2 | Companion bank B, undivided |

## Verification
The assertions assume that the select codes and `park_i` are static inputs. They may change at any moment between clock edges, but not close to an edge, and the source clock runs freely. The stimulus honours this by changing inputs only at quarter-period points. Seeded random select codes, including the illegal 2'b11, are applied just after an observed output rise, which lands each change in the middle of a period. The stimulus parks the divider in the low half of a clock cycle, so the release edge is known in advance.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int MAX_RATIO = 12;
  localparam int RW = $clog2(MAX_RATIO + 1);

  typedef logic [RW-1:0] ratio_t;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_BAD  = 2'b11
  } lvl_e;

  // Ternary level to row/column index; the unused code folds onto MID.
  function automatic ratio_t lvl_index(input logic [1:0] code);
    case (lvl_e'(code))
      LVL_LOW:  return ratio_t'(0);
      LVL_HIGH: return ratio_t'(2);
      default:  return ratio_t'(1);
    endcase
  endfunction
endpackage

// File: rtl/fbdiv_sel_decode.sv
module fbdiv_sel_decode
  import fbdiv_pkg::*;
(
  input  logic [1:0] sel_hi_i,
  input  logic [1:0] sel_lo_i,
  output ratio_t     ratio_o
);
  ratio_t idx;

  // Indices 0..5 give ratios 1..6; indices 6..8 give 8, 10, 12.
  always_comb begin
    idx = ratio_t'(3) * lvl_index(sel_hi_i) + lvl_index(sel_lo_i);
    if (idx < ratio_t'(6)) ratio_o = idx + ratio_t'(1);
    else                   ratio_o = (idx - ratio_t'(2)) << 1;
  end
endmodule

// File: rtl/fbdiv_park_seq.sv
module fbdiv_park_seq #(
  parameter int PARK_EDGES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic park_i,
  output logic frz_o,
  output logic hold_o
);
  localparam int PW = $clog2(PARK_EDGES + 1);

  logic [PW-1:0] pcnt_q, pcnt_n;
  logic          hold_q;

  always_comb begin
    frz_o = park_i && (pcnt_q >= PW'(PARK_EDGES - 1));
    if (!park_i)                          pcnt_n = '0;
    else if (pcnt_q == PW'(PARK_EDGES))   pcnt_n = pcnt_q;
    else                                  pcnt_n = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      hold_q <= 1'b1;
    end else begin
      pcnt_q <= pcnt_n;
      hold_q <= park_i;
    end
  end

  assign hold_o = hold_q;

  assert_park_count_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= PW'(PARK_EDGES));
endmodule

// File: rtl/fbdiv_core.sv
module fbdiv_core
  import fbdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t ratio_i,
  input  logic   frz_i,
  input  logic   hold_i,
  output logic   div_o
);
  ratio_t cnt_q, cnt_n, act_q, act_n;
  logic   ph_r_q, ph_r_n, ph_f_q;
  logic   at_end, div_raw;

  // Rising-edge phase is high for floor(N/2) cycles; odd ratios add
  // the half cycle through the falling-edge copy.
  always_comb begin
    at_end = (cnt_q == act_q - ratio_t'(1));
    if (frz_i) begin
      act_n  = ratio_i;
      cnt_n  = ratio_i - ratio_t'(1);
      ph_r_n = 1'b0;
    end else if (at_end) begin
      act_n  = ratio_i;
      cnt_n  = '0;
      ph_r_n = (ratio_i >> 1) != '0;
    end else begin
      act_n  = act_q;
      cnt_n  = cnt_q + ratio_t'(1);
      ph_r_n = (cnt_q + ratio_t'(1)) < (act_q >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      act_q  <= ratio_t'(1);
      ph_r_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      ph_r_q <= ph_r_n;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_f_q <= 1'b0;
    else         ph_f_q <= ph_r_q;
  end

  always_comb begin
    if (act_q == ratio_t'(1)) div_raw = clk_i;
    else if (act_q[0])        div_raw = ph_r_q | ph_f_q;
    else                      div_raw = ph_r_q;
    div_o = div_raw & ~hold_i;
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < act_q);

  assert_ratio_switch_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> ($past(cnt_q) == $past(act_q) - ratio_t'(1) || $past(frz_i)));

  assert_park_state_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_i |=> (!ph_r_q && cnt_q == act_q - ratio_t'(1)));

  assert_ratio_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_i inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd10, 4'd12});

  assert_phase_starts_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ph_r_q) |-> cnt_q == '0);
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter int PARK_EDGES  = 5,
  parameter int SYNC_STAGES = 2,
  parameter int PAIR_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        sel_hi_i,
  input  logic [1:0]        sel_lo_i,
  input  logic              park_i,
  output logic [PAIR_W-1:0] fb_o,
  output logic [PAIR_W-1:0] bank_a_o,
  output logic [PAIR_W-1:0] bank_b_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic   rst_n_s;
  ratio_t ratio;
  logic   frz, hold, div;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = sync_q[SYNC_STAGES-1];

  fbdiv_sel_decode u_dec (
    .sel_hi_i (sel_hi_i),
    .sel_lo_i (sel_lo_i),
    .ratio_o  (ratio)
  );

  fbdiv_park_seq #(.PARK_EDGES(PARK_EDGES)) u_park (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .park_i (park_i),
    .frz_o  (frz),
    .hold_o (hold)
  );

  fbdiv_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .ratio_i (ratio),
    .frz_i   (frz),
    .hold_i  (hold),
    .div_o   (div)
  );

  for (genvar g = 0; g < PAIR_W; g++) begin : g_out
    assign fb_o[g]     = div;
    assign bank_a_o[g] = clk_i & ~hold;
    assign bank_b_o[g] = clk_i & ~hold;
  end

  assert_hold_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    hold |-> (fb_o == '0 && bank_a_o == '0 && bank_b_o == '0));
endmodule

// File: tb/sim_fbdiv_top.sv
module sim_fbdiv_top;
  localparam int CLK_PERIOD = 20;

  logic       clk, rst_n, park;
  logic [1:0] su, sl;
  wire  [1:0] fb, ba, bb;
  int n_chk = 0;
  int n_bad = 0;
  int cur_ratio;

  fbdiv_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_hi_i(su), .sel_lo_i(sl), .park_i(park),
    .fb_o(fb), .bank_a_o(ba), .bank_b_o(bb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lv(input logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b10) return 2;
    return 1;
  endfunction

  function automatic int exp_ratio(input logic [1:0] u, input logic [1:0] l);
    case (lv(u) * 3 + lv(l))
      0: return 1;  1: return 2;  2: return 3;
      3: return 4;  4: return 5;  5: return 6;
      6: return 8;  7: return 10; default: return 12;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic lane_check();
    check(fb[0] == fb[1], "R4 pair match", fb[1], fb[0]);
    check(ba == {2{clk}} && bb == {2{clk}}, "R5 companion undivided",
          {ba, bb}, {4{clk}});
  endtask

  task automatic sync_rise();
    logic prev;
    bit   found;
    prev  = fb[0];
    found = 0;
    for (int i = 0; i < 64 && !found; i++) begin
      tick();
      if (!prev && fb[0]) found = 1;
      prev = fb[0];
    end
    check(found, "R3 output rise seen", found, 1);
  endtask

  // Current sample is the first high one; returns positioned on the next rise.
  task automatic meas(input int n, input string tag);
    int h, l;
    bit seen_low, done;
    h = 1; l = 0; seen_low = 0; done = 0;
    for (int i = 0; i < 64 && !done; i++) begin
      tick();
      lane_check();
      if (!seen_low) begin
        if (fb[0]) h++;
        else begin seen_low = 1; l = 1; end
      end else begin
        if (!fb[0]) l++;
        else done = 1;
      end
    end
    check(h == n, {tag, " high half-cycles"}, h, n);
    check(l == n, {tag, " low half-cycles"}, l, n);
    check(h + l == 2 * n, {tag, " period"}, h + l, 2 * n);
  endtask

  task automatic set_sel(input logic [1:0] u, input logic [1:0] l);
    su = u; sl = l;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic park_test(input logic [1:0] u, input logic [1:0] l);
    int n;
    bit quiet;
    while (clk) tick();
    park = 1'b1;
    tick();
    check(fb == 0 && ba == 0 && bb == 0, "R7 outputs low on park", {fb, ba, bb}, 0);
    set_sel(u, l);
    n = exp_ratio(u, l);
    quiet = 1;
    for (int i = 0; i < 16; i++) begin
      tick();
      if (fb != 0 || ba != 0 || bb != 0) quiet = 0;
    end
    check(quiet, "R7 outputs low while parked", quiet, 1);
    while (clk) tick();
    park = 1'b0;
    tick();
    check(fb == 2'b11, "R8 rise at release edge", fb, 3);
    check(ba == 2'b11, "R8 companion resumes at release", ba, 3);
    meas(n, "R8 first period after park");
    meas(n, "R8 second period after park");
    cur_ratio = n;
  endtask

  initial begin
    int nr;
    logic [1:0] ru, rl;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; park = 1'b0; su = 2'b00; sl = 2'b00;
    repeat (4) tick();
    check(fb == 0 && ba == 0 && bb == 0, "R9 outputs low in reset", {fb, ba, bb}, 0);
    rst_n = 1'b1;
    repeat (10) tick();
    cur_ratio = 1;

    // Directed sweep of all sixteen code pairs (R1, R2, R6, R3).
    for (int u = 0; u < 4; u++) begin
      for (int l = 0; l < 4; l++) begin
        sync_rise();
        set_sel(2'(u), 2'(l));
        nr = exp_ratio(2'(u), 2'(l));
        meas(cur_ratio, "R6 period in progress keeps old ratio");
        if (u == 3 || l == 3) meas(nr, "R2 illegal code as MID");
        else                  meas(nr, "R1 ratio map");
        meas(nr, "R3 steady period");
        cur_ratio = nr;
      end
    end

    // Park / deterministic state across odd, even and undivided ratios.
    park_test(2'b01, 2'b01);
    park_test(2'b10, 2'b10);
    park_test(2'b00, 2'b00);
    park_test(2'b00, 2'b10);

    // Random select changes mid-period.
    for (int k = 0; k < 40; k++) begin
      ru = 2'($urandom_range(0, 3));
      rl = 2'($urandom_range(0, 3));
      sync_rise();
      set_sel(ru, rl);
      nr = exp_ratio(ru, rl);
      meas(cur_ratio, "R6 random old period");
      meas(nr, "R3 random new period");
      cur_ratio = nr;
    end

    // Reset asserted mid-run acts at once.
    sync_rise();
    tick();
    rst_n = 1'b0;
    #1;
    check(fb == 0 && ba == 0 && bb == 0, "R9 async reset clears outputs", {fb, ba, bb}, 0);
    tick();
    check(fb == 0 && ba == 0 && bb == 0, "R9 outputs held low", {fb, ba, bb}, 0);
    rst_n = 1'b1;
    repeat (10) tick();
    sync_rise();
    meas(cur_ratio, "R9 ratio after reset release");

    finish_run();
  end
endmodule